// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small accumulator processor built around one shared bus. Each instruction is split into eight micro-steps. A three-bit step counter moves on the falling clock edge. For every step the block looks up a 16-bit control word, which the datapath registers sample on the next rising edge. The lookup address is made of the latched zero and carry flags, the four-bit opcode from the instruction register and the current step.

Conditional jumps need no opcode test in the jump path. The table holds four banks of microcode, one for each combination of the two flags. A jump-on-carry sequence is present only in the banks where carry is set, and a jump-on-zero sequence only where zero is set. The halt micro-operation latches a halted state. That state freezes the counter and masks the control word until reset.

Reset is asynchronous and active low. Its release is synchronised to the falling-edge domain, so the counter first advances on the third falling edge after `rst_n` rises.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, `halted` is 0 and `ctrl_word` is the first fetch word 16'h4004 (step 0). After `rst_n` rises, step 0 is still shown after two falling edges, and step 1 appears at the third.
- R2: While not halted, each falling clock edge advances the step by exactly one, and `halted` stays 0.
- R3: After step 7 the step wraps to 0, so every opcode occupies eight steps.
- R4: For every opcode and flag value, step 0 gives 16'h4004 (address register load, program counter drive) and step 1 gives 16'h1408 (memory read, instruction register load, program counter increment).
- R5: Control bits, from bit 15 down to bit 0: halt, address-register load, memory write, memory read, instruction-operand drive, instruction-register load, accumulator load, accumulator drive, ALU drive, ALU subtract, B-register load, output-register load, counter increment, counter drive, counter load, flag load.
- R6: Opcode 1 (load) gives 16'h4800 at step 2 and 16'h1200 at step 3. Opcode 2 (add) gives 16'h4800, 16'h1020 and 16'h0281 at steps 2 to 4. Opcode 3 (subtract) is the same as add but gives 16'h02C1 at step 4. Opcode 4 (store) gives 16'h4800 at step 2 and 16'h2100 at step 3.
- R7: At step 2, opcode 5 (load immediate) gives 16'h0A00, opcode 6 (jump) gives 16'h0802, and opcode 14 (output) gives 16'h0110.
- R8: The table address is {zero, carry, opcode, step}. Opcode 7 gives 16'h0802 at step 2 only when carry is 1. Opcode 8 gives 16'h0802 at step 2 only when zero is 1. In every other case they give zero after the fetch.
- R9: Opcodes 0 and 9 to 13 give zero at steps 2 to 7. Every step not listed in R6 to R8 and R10 gives zero.
- R10: Opcode 15 gives 16'h8000 at step 2. At the falling edge that ends that step, `halted` rises and the counter stops.
- R11: While halted, `ctrl_word` is 16'h8000 and the step does not change, whatever the opcode and flags. Only reset clears `halted`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the step counter moves on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode from the instruction register |
| flag_carry | input | 1 | Latched carry flag |
| flag_zero | input | 1 | Latched zero flag |
| ctrl_word | output | 16 | Control word for the current step |
| halted | output | 1 | High once the halt micro-operation has been taken |

## Verification
On every falling edge the assertions check the counter's behaviour: the single-step advance, the wrap from 7 to 0, the frozen step and sticky halt, and the fixed fetch words at steps 0 and 1. They also check that a halted block shows only the halt bit. Only the bench's sweep can show the contents of the table. That sweep covers all sixteen opcodes under all four flag banks at every step, the reset-release latency, and the fact that a halted block ignores changes to the opcode and flags.

// File: rtl/ucs_pkg.sv
`timescale 1ns/1ps
package ucs_pkg;

  localparam int STEP_W  = 3;
  localparam int OPC_W   = 4;
  localparam int FLAG_W  = 2;
  localparam int CW_W    = 16;
  localparam int ADDR_W  = FLAG_W + OPC_W + STEP_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CARRY_POS = STEP_W + OPC_W;
  localparam int ZERO_POS  = STEP_W + OPC_W + 1;

  // control word bit positions (the datapath decodes these)
  localparam int CB_HALT    = 15;
  localparam int CB_MAR_LD  = 14;
  localparam int CB_MEM_WR  = 13;
  localparam int CB_MEM_RD  = 12;
  localparam int CB_IR_OE   = 11;
  localparam int CB_IR_LD   = 10;
  localparam int CB_ACC_LD  = 9;
  localparam int CB_ACC_OE  = 8;
  localparam int CB_ALU_OE  = 7;
  localparam int CB_ALU_SUB = 6;
  localparam int CB_BREG_LD = 5;
  localparam int CB_OUT_LD  = 4;
  localparam int CB_PC_INC  = 3;
  localparam int CB_PC_OE   = 2;
  localparam int CB_PC_LD   = 1;
  localparam int CB_FLG_LD  = 0;

  typedef logic [CW_W-1:0] cword_t;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP    = 4'd0,
    OP_LOAD   = 4'd1,
    OP_ADD    = 4'd2,
    OP_SUB    = 4'd3,
    OP_STORE  = 4'd4,
    OP_IMM    = 4'd5,
    OP_JUMP   = 4'd6,
    OP_JCARRY = 4'd7,
    OP_JZERO  = 4'd8,
    OP_OUTPUT = 4'd14,
    OP_HALT   = 4'd15
  } op_e;

  function automatic cword_t cbit(input int idx);
    cword_t w;
    w = '0;
    w[idx] = 1'b1;
    return w;
  endfunction

  // one table entry, computed from its address {zero, carry, opcode, step}
  function automatic cword_t ucode_entry(input logic [ADDR_W-1:0] a);
    logic [STEP_W-1:0] st;
    logic [OPC_W-1:0]  op;
    logic              c_f;
    logic              z_f;
    cword_t            w;
    cword_t            jump_w;
    cword_t            mem_addr_w;
    st  = a[STEP_W-1:0];
    op  = a[CARRY_POS-1:STEP_W];
    c_f = a[CARRY_POS];
    z_f = a[ZERO_POS];
    w   = '0;
    jump_w     = cbit(CB_IR_OE) | cbit(CB_PC_LD);
    mem_addr_w = cbit(CB_IR_OE) | cbit(CB_MAR_LD);
    if (st == STEP_W'(0)) begin
      w = cbit(CB_MAR_LD) | cbit(CB_PC_OE);
    end else if (st == STEP_W'(1)) begin
      w = cbit(CB_MEM_RD) | cbit(CB_IR_LD) | cbit(CB_PC_INC);
    end else begin
      case (op)
        OP_LOAD: begin
          if (st == STEP_W'(2)) w = mem_addr_w;
          else if (st == STEP_W'(3)) w = cbit(CB_MEM_RD) | cbit(CB_ACC_LD);
        end
        OP_ADD, OP_SUB: begin
          if (st == STEP_W'(2)) w = mem_addr_w;
          else if (st == STEP_W'(3)) w = cbit(CB_MEM_RD) | cbit(CB_BREG_LD);
          else if (st == STEP_W'(4)) begin
            w = cbit(CB_ALU_OE) | cbit(CB_ACC_LD) | cbit(CB_FLG_LD);
            if (op == OP_SUB) w = w | cbit(CB_ALU_SUB);
          end
        end
        OP_STORE: begin
          if (st == STEP_W'(2)) w = mem_addr_w;
          else if (st == STEP_W'(3)) w = cbit(CB_ACC_OE) | cbit(CB_MEM_WR);
        end
        OP_IMM: begin
          if (st == STEP_W'(2)) w = cbit(CB_IR_OE) | cbit(CB_ACC_LD);
        end
        OP_JUMP: begin
          if (st == STEP_W'(2)) w = jump_w;
        end
        OP_JCARRY: begin
          if (st == STEP_W'(2) && c_f) w = jump_w;
        end
        OP_JZERO: begin
          if (st == STEP_W'(2) && z_f) w = jump_w;
        end
        OP_OUTPUT: begin
          if (st == STEP_W'(2)) w = cbit(CB_ACC_OE) | cbit(CB_OUT_LD);
        end
        OP_HALT: begin
          if (st == STEP_W'(2)) w = cbit(CB_HALT);
        end
        default: w = '0;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/ucs_rst_sync.sv
`timescale 1ns/1ps
module ucs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  // falling-edge domain: assertion is immediate, release takes STAGES edges
  always_ff @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/ucs_step_ctr.sv
`timescale 1ns/1ps
module ucs_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              halt_req,
  output logic [STEP_W-1:0] step_o,
  output logic              halted_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = {STEP_W{1'b1}};

  logic [STEP_W-1:0] step_q, step_d;
  logic              halt_q, halt_d;
  logic              adv_en;

  always_comb begin
    step_d = step_q;
    halt_d = halt_q;
    adv_en = !halt_q && !halt_req;
    if (adv_en) begin
      step_d = (step_q == LAST_STEP) ? '0 : step_q + 1'b1;
    end
    if (halt_req) begin
      halt_d = 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      halt_q <= 1'b0;
    end else begin
      step_q <= step_d;
      halt_q <= halt_d;
    end
  end

  assign step_o   = step_q;
  assign halted_o = halt_q;
endmodule

// File: rtl/ucs_ucode_rom.sv
`timescale 1ns/1ps
module ucs_ucode_rom
  import ucs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output cword_t        word
);
  localparam int WORDS = 1 << AW;

  cword_t table_w [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_entry
    assign table_w[i] = ucode_entry(AW'(i));
  end

  assign word = table_w[addr];
endmodule

// File: rtl/ucode_sequencer.sv
`timescale 1ns/1ps
module ucode_sequencer
  import ucs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             flag_carry,
  input  logic             flag_zero,
  output logic [CW_W-1:0]  ctrl_word,
  output logic             halted
);
  logic              rst_sync_n;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] rom_addr;
  cword_t            rom_word;

  ucs_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  ucs_step_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .halt_req (rom_word[CB_HALT]),
    .step_o   (step_q),
    .halted_o (halted)
  );

  // bank select by flags: the jump path never decodes the opcode
  assign rom_addr = {flag_zero, flag_carry, opcode, step_q};

  ucs_ucode_rom #(.AW(ADDR_W)) u_rom (
    .addr (rom_addr),
    .word (rom_word)
  );

  assign ctrl_word = halted ? cbit(CB_HALT) : rom_word;
endmodule

// File: rtl/ucs_checker.sv
`timescale 1ns/1ps
module ucs_checker
  import ucs_pkg::*;
(
  input logic              clk,
  input logic              rst_ni,
  input logic [STEP_W-1:0] step,
  input logic              halted,
  input logic [CW_W-1:0]   ctrl_word
);
  // R2: single-step advance while running
  a_r2_step_advance: assert property (@(negedge clk) disable iff (!rst_ni)
    (!halted && !ctrl_word[CB_HALT] && step != {STEP_W{1'b1}})
      |=> (step == STEP_W'($past(step) + 1'b1)));

  // R3: wrap after the last step
  a_r3_wrap: assert property (@(negedge clk) disable iff (!rst_ni)
    (!halted && !ctrl_word[CB_HALT] && step == {STEP_W{1'b1}}) |=> (step == '0));

  // R4: fixed fetch words
  a_r4_fetch_step0: assert property (@(negedge clk) disable iff (!rst_ni)
    (!halted && step == STEP_W'(0)) |-> (ctrl_word == 16'h4004));
  a_r4_fetch_step1: assert property (@(negedge clk) disable iff (!rst_ni)
    (!halted && step == STEP_W'(1)) |-> (ctrl_word == 16'h1408));

  // R10: halt bit latches the halted state
  a_r10_halt_latch: assert property (@(negedge clk) disable iff (!rst_ni)
    ctrl_word[CB_HALT] |=> halted);

  // R11: halted is sticky, the step frozen and only the halt bit shown
  a_r11_halt_sticky: assert property (@(negedge clk) disable iff (!rst_ni)
    halted |=> (halted && $stable(step)));
  a_r11_halt_word: assert property (@(negedge clk) disable iff (!rst_ni)
    halted |-> (ctrl_word == 16'h8000));
endmodule

bind ucode_sequencer ucs_checker u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .step      (step_q),
  .halted    (halted),
  .ctrl_word (ctrl_word)
);

// File: tb/ucode_sequencer_test.sv
`timescale 1ns/1ps
module ucode_sequencer_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  opcode;
  logic        flag_carry;
  logic        flag_zero;
  logic [15:0] ctrl_word;
  logic        halted;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  ucode_sequencer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .flag_carry (flag_carry),
    .flag_zero  (flag_zero),
    .ctrl_word  (ctrl_word),
    .halted     (halted)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h (op %0d c %0d z %0d)",
               tag, act, exp, opcode, flag_carry, flag_zero);
    end
  endtask

  // expected word from the requirement text (R4, R6-R10)
  function automatic logic [15:0] exp_word(input int op, input bit c, input bit z, input int s);
    if (s == 0) return 16'h4004;
    if (s == 1) return 16'h1408;
    case (op)
      1:  return (s == 2) ? 16'h4800 : (s == 3) ? 16'h1200 : 16'h0000;
      2:  return (s == 2) ? 16'h4800 : (s == 3) ? 16'h1020 : (s == 4) ? 16'h0281 : 16'h0000;
      3:  return (s == 2) ? 16'h4800 : (s == 3) ? 16'h1020 : (s == 4) ? 16'h02C1 : 16'h0000;
      4:  return (s == 2) ? 16'h4800 : (s == 3) ? 16'h2100 : 16'h0000;
      5:  return (s == 2) ? 16'h0A00 : 16'h0000;
      6:  return (s == 2) ? 16'h0802 : 16'h0000;
      7:  return (s == 2 && c) ? 16'h0802 : 16'h0000;
      8:  return (s == 2 && z) ? 16'h0802 : 16'h0000;
      14: return (s == 2) ? 16'h0110 : 16'h0000;
      15: return (s == 2) ? 16'h8000 : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input int op, input int s);
    if (s < 2) return "R4";
    if (op >= 1 && op <= 4) return "R6";
    if (op == 5 || op == 6 || op == 14) return "R7";
    if (op == 7 || op == 8) return "R8";
    if (op == 15) return "R10";
    return "R9";
  endfunction

  task automatic run_case(input int op, input bit c, input bit z);
    rst_n = 1'b0;
    opcode = 4'(op);
    flag_carry = c;
    flag_zero = z;
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset word", ctrl_word, 16'h4004);
    check("R1 reset halted", {15'd0, halted}, 16'h0000);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    check("R1 release latency", ctrl_word, exp_word(op, c, z, 0));
    for (int s = 1; s < 8; s++) begin
      @(negedge clk); #1;
      if (op == 15 && s >= 3) begin
        check("R10 halted rises", {15'd0, halted}, 16'h0001);
        check("R11 halted word", ctrl_word, 16'h8000);
      end else begin
        check(tag_of(op, s), ctrl_word, exp_word(op, c, z, s));
        check("R2 not halted", {15'd0, halted}, 16'h0000);
        if (op == 2 && s == 4)
          check("R5 bit positions", {13'd0, ctrl_word[9], ctrl_word[7], ctrl_word[0]}, 16'h0007);
      end
    end
    @(negedge clk); #1;
    if (op != 15) begin
      check("R3 wrap to step 0", ctrl_word, 16'h4004);
      @(negedge clk); #1;
      check("R3 step 1 after wrap", ctrl_word, 16'h1408);
    end else begin
      opcode = 4'd1;
      flag_carry = ~c;
      flag_zero = ~z;
      @(negedge clk); #1;
      check("R11 opcode ignored", ctrl_word, 16'h8000);
      check("R11 still halted", {15'd0, halted}, 16'h0001);
      rst_n = 1'b0;
      #1;
      check("R11 reset clears halt", {15'd0, halted}, 16'h0000);
      check("R11 reset word", ctrl_word, 16'h1408 & 16'h0000 | 16'h4004);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    opcode = 4'd0;
    flag_carry = 1'b0;
    flag_zero = 1'b0;
    for (int op = 0; op < 16; op++) begin
      for (int b = 0; b < 4; b++) begin
        run_case(op, b[0], b[1]);   // b = {zero, carry} bank index (R8)
      end
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule